// File: doc/BRIEF.md
# Address-Triggered Masked Fault Injector

This block sits beside a processor's memory interface and watches every access that goes past: instruction fetches, data loads and data stores, each carrying an address and a data word. Each access is passed through a one-cycle register stage. When a programmed trigger is met, the data word of that access leaves the stage corrupted instead of intact. The corruption is confined to the bits chosen by a fault mask. A selectable bit operation sets the new value of those bits.

A trigger is built from up to two conditions. One is an address match on a chosen set of access kinds. The other is a cycle count since start-up reaching a threshold. A trigger fires only when every enabled condition holds. The trigger depends on the accesses themselves, not on a delay after some event. A run with the same configuration and the same access stream therefore injects at the same access every time.

By default the injector fires once and then disarms until it is re-armed. A repeat mode lets it corrupt every access that matches. A pulse output marks the cycle in which corrupted data is presented.

Top module: `fault_injector`

## Requirements
- R1: While reset is active, and after it is released with no access, `out_valid` and `inj_pulse` are 0.
- R2: Access kinds are encoded on `acc_kind` as 00 idle, 01 fetch, 10 load and 11 store. A non-idle access with `acc_valid` high appears on `out_valid`/`out_data` exactly one clock later. If it does not trigger, the data is unchanged. Idle kinds and accesses with `acc_valid` low produce no `out_valid`.
- R3: `kind_en` bit 0 enables fetches, bit 1 loads and bit 2 stores. With any of these bits set, the address condition holds only for an access whose kind bit is set and whose address equals `trig_addr`.
- R4: With `time_en` set, the time condition holds once the count of cycles since reset is at least `time_thresh`, and it stays true from then on.
- R5: The trigger fires on a valid non-idle access only when all enabled conditions hold. With `kind_en` = 000 and `time_en` = 0, it never fires.
- R6: On an injection, bits of `out_data` whose `fault_mask` bit is 0 equal the input data.
- R7: `fault_op` selects the operation on masked bits: 00 force to 0, 01 force to 1, 10 invert, 11 bridge. Bridge means bit i becomes d[i] AND d[i+1], and the top bit pairs with bit 0.
- R8: With `repeat_mode` = 0, the injector disarms after one injection, so later matching accesses pass unchanged. A one-cycle `rearm` pulse arms it again.
- R9: With `repeat_mode` = 1, every matching access is corrupted.
- R10: `inj_pulse` is high in exactly the cycle in which the corrupted word is on `out_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trig_addr | input | AW | Address compared for the address condition |
| kind_en | input | 3 | Access kinds taking part in the address condition (fetch, load, store) |
| time_en | input | 1 | Enables the elapsed-cycle condition |
| time_thresh | input | CW | Cycle count at which the time condition becomes true |
| fault_mask | input | DW | Bits that an injection may alter |
| fault_op | input | 2 | Bit operation applied to masked bits |
| repeat_mode | input | 1 | 1: inject on every match; 0: inject once per arming |
| rearm | input | 1 | Arms the one-shot injector again |
| acc_valid | input | 1 | Access strobe |
| acc_kind | input | 2 | Access kind |
| acc_addr | input | AW | Access address |
| acc_data | input | DW | Access data word |
| out_valid | output | 1 | Registered access strobe |
| out_data | output | DW | Registered, possibly corrupted data word |
| inj_pulse | output | 1 | High when `out_data` carries an injected fault |

## Verification
The assertions assume that the configuration inputs (mask, operation, threshold and enables) stay stable while an access is in flight. Several checks compare the output with the mask and data one cycle earlier, so they rely on this. The stimulus changes configuration only on the falling edge that presents a new access, so each access and its configuration are sampled together. Reset is applied through the synchronous release stage. The bench waits past it before driving accesses, so the cycle count that the time condition uses is known only to within a few cycles. Time thresholds are therefore tested well clear of either side of the boundary.

// File: rtl/fi_pkg.sv
package fi_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'b00,
    ACC_FETCH = 2'b01,
    ACC_LOAD  = 2'b10,
    ACC_STORE = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    OP_CLEAR  = 2'b00,
    OP_SET    = 2'b01,
    OP_INVERT = 2'b10,
    OP_BRIDGE = 2'b11
  } fault_op_e;

  localparam int NUM_KINDS = 3;
endpackage

// File: rtl/fi_cycle_timer.sv
module fi_cycle_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] thresh,
  output logic          reached
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = (cnt_q != CNT_MAX);
    cnt_d  = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign reached = (cnt_q >= thresh);

  // R4: once reached with a steady threshold, the condition stays true
  assert_time_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reached) && $stable(thresh)) |-> reached);
endmodule

// File: rtl/fi_trigger.sv
module fi_trigger
  import fi_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_valid,
  input  logic [1:0]           acc_kind,
  input  logic [AW-1:0]        acc_addr,
  input  logic [AW-1:0]        trig_addr,
  input  logic [NUM_KINDS-1:0] kind_en,
  input  logic                 time_en,
  input  logic                 time_reached,
  input  logic                 repeat_mode,
  input  logic                 rearm,
  output logic                 fire
);
  logic                 armed_q, armed_d;
  logic [NUM_KINDS-1:0] kind_hit;
  logic                 is_access, addr_ok, time_ok, any_cond;

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
    assign kind_hit[k] = kind_en[k] && (acc_kind == 2'(k + 1));
  end

  always_comb begin
    is_access = acc_valid && (acc_kind != ACC_IDLE);
    any_cond  = (|kind_en) || time_en;
    addr_ok   = (kind_en == '0) || ((|kind_hit) && (acc_addr == trig_addr));
    time_ok   = !time_en || time_reached;
    fire      = is_access && any_cond && addr_ok && time_ok && armed_q;
  end

  always_comb begin
    armed_d = armed_q;
    if (rearm)                     armed_d = 1'b1;
    else if (fire && !repeat_mode) armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b1;
    else        armed_q <= armed_d;
  end

  // R5: an enabled time condition gates firing (timer is a separate block)
  assert_time_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && time_en) |-> time_reached);

  // R8: one-shot mode never fires twice without a rearm between
  assert_single_shot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fire) && !$past(repeat_mode) && !$past(rearm) && !rearm) |-> !fire);
endmodule

// File: rtl/fi_corrupt.sv
module fi_corrupt
  import fi_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] data_in,
  input  logic [DW-1:0] mask,
  input  logic [1:0]    op,
  output logic [DW-1:0] data_out
);
  logic [DW-1:0] bridged;
  logic [DW-1:0] altered;

  for (genvar i = 0; i < DW; i++) begin : g_bridge
    assign bridged[i] = data_in[i] & data_in[(i + 1) % DW];
  end

  always_comb begin
    case (op)
      OP_CLEAR:  altered = '0;
      OP_SET:    altered = '1;
      OP_INVERT: altered = ~data_in;
      default:   altered = bridged;
    endcase
    data_out = (data_in & ~mask) | (altered & mask);
  end
endmodule

// File: rtl/fault_injector.sv
module fault_injector
  import fi_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        trig_addr,
  input  logic [NUM_KINDS-1:0] kind_en,
  input  logic                 time_en,
  input  logic [CW-1:0]        time_thresh,
  input  logic [DW-1:0]        fault_mask,
  input  logic [1:0]           fault_op,
  input  logic                 repeat_mode,
  input  logic                 rearm,
  input  logic                 acc_valid,
  input  logic [1:0]           acc_kind,
  input  logic [AW-1:0]        acc_addr,
  input  logic [DW-1:0]        acc_data,
  output logic                 out_valid,
  output logic [DW-1:0]        out_data,
  output logic                 inj_pulse
);
  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic          time_reached, fire, is_access;
  logic [DW-1:0] corrupt_data;
  logic [DW-1:0] data_d;

  fi_cycle_timer #(.CW(CW)) i_timer (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .thresh  (time_thresh),
    .reached (time_reached)
  );

  fi_trigger #(.AW(AW)) i_trigger (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .acc_valid    (acc_valid),
    .acc_kind     (acc_kind),
    .acc_addr     (acc_addr),
    .trig_addr    (trig_addr),
    .kind_en      (kind_en),
    .time_en      (time_en),
    .time_reached (time_reached),
    .repeat_mode  (repeat_mode),
    .rearm        (rearm),
    .fire         (fire)
  );

  fi_corrupt #(.DW(DW)) i_corrupt (
    .data_in  (acc_data),
    .mask     (fault_mask),
    .op       (fault_op),
    .data_out (corrupt_data)
  );

  always_comb begin
    is_access = acc_valid && (acc_kind != ACC_IDLE);
    data_d    = fire ? corrupt_data : acc_data;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      out_valid <= 1'b0;
      inj_pulse <= 1'b0;
    end else begin
      out_valid <= is_access;
      inj_pulse <= fire;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)     out_data <= '0;
    else if (is_access) out_data <= data_d;
  end

  // R2: no output strobe without a strobed access one cycle earlier
  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n_int)
    !$past(acc_valid) |-> !out_valid);

  // R6: unmasked bits of the output equal the input word
  assert_unmasked_kept_R6: assert property (@(posedge clk) disable iff (!rst_n_int)
    out_valid |-> (((out_data ^ $past(acc_data)) & ~$past(fault_mask)) == '0));

  // R7: force-to-1 sets every masked bit
  assert_set_op_R7: assert property (@(posedge clk) disable iff (!rst_n_int)
    (inj_pulse && ($past(fault_op) == OP_SET)) |-> ((out_data & $past(fault_mask)) == $past(fault_mask)));

  // R10: the pulse marks a presented word
  assert_pulse_with_data_R10: assert property (@(posedge clk) disable iff (!rst_n_int)
    inj_pulse |-> out_valid);
endmodule

// File: tb/test_fault_injector.sv
module test_fault_injector;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int CW = 16;
  localparam int NV = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] trig_addr;
  logic [2:0]    kind_en;
  logic          time_en;
  logic [CW-1:0] time_thresh;
  logic [DW-1:0] fault_mask;
  logic [1:0]    fault_op;
  logic          repeat_mode;
  logic          rearm;
  logic          acc_valid;
  logic [1:0]    acc_kind;
  logic [AW-1:0] acc_addr;
  logic [DW-1:0] acc_data;
  logic          out_valid;
  logic [DW-1:0] out_data;
  logic          inj_pulse;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  fault_injector #(.AW(AW), .DW(DW), .CW(CW)) i_fault_injector (
    .clk(clk), .rst_n(rst_n), .trig_addr(trig_addr), .kind_en(kind_en),
    .time_en(time_en), .time_thresh(time_thresh), .fault_mask(fault_mask),
    .fault_op(fault_op), .repeat_mode(repeat_mode), .rearm(rearm),
    .acc_valid(acc_valid), .acc_kind(acc_kind), .acc_addr(acc_addr),
    .acc_data(acc_data), .out_valid(out_valid), .out_data(out_data),
    .inj_pulse(inj_pulse)
  );

  typedef struct packed {
    logic [2:0]  ken;
    logic [1:0]  op;
    logic [31:0] mask;
    logic        valid;
    logic [1:0]  kind;
    logic [15:0] addr;
    logic [31:0] data;
    logic        exp_valid;
    logic        exp_pulse;
  } vec_t;

  // kinds: 1 fetch, 2 load, 3 store, 0 idle; ops: 0 clear, 1 set, 2 invert, 3 bridge
  localparam vec_t VECS [NV] = '{
    '{3'b001, 2'd2, 32'h000000FF, 1'b1, 2'd1, 16'h1000, 32'h12345678, 1'b1, 1'b1},
    '{3'b001, 2'd2, 32'h000000FF, 1'b1, 2'd2, 16'h1000, 32'h12345678, 1'b1, 1'b0},
    '{3'b010, 2'd1, 32'hF0000000, 1'b1, 2'd2, 16'h1000, 32'h00000000, 1'b1, 1'b1},
    '{3'b100, 2'd1, 32'hF0000000, 1'b1, 2'd3, 16'h1004, 32'h00000000, 1'b1, 1'b0},
    '{3'b100, 2'd0, 32'hFFFF0000, 1'b1, 2'd3, 16'h1000, 32'hFFFFFFFF, 1'b1, 1'b1},
    '{3'b111, 2'd3, 32'hFFFFFFFF, 1'b1, 2'd1, 16'h1000, 32'hA5A55A5A, 1'b1, 1'b1},
    '{3'b000, 2'd3, 32'hFFFFFFFF, 1'b1, 2'd3, 16'h1000, 32'hA5A55A5A, 1'b1, 1'b0},
    '{3'b110, 2'd3, 32'h80000001, 1'b1, 2'd2, 16'h1000, 32'h00000001, 1'b1, 1'b1},
    '{3'b111, 2'd2, 32'hFFFFFFFF, 1'b1, 2'd0, 16'h1000, 32'h00000001, 1'b0, 1'b0},
    '{3'b111, 2'd2, 32'hFFFFFFFF, 1'b0, 2'd1, 16'h1000, 32'h00000001, 1'b0, 1'b0}
  };

  function automatic logic [31:0] model(input logic [1:0] op, input logic [31:0] m,
                                        input logic [31:0] d);
    logic [31:0] r;
    r = d;
    for (int i = 0; i < 32; i++) begin
      if (m[i]) begin
        case (op)
          2'd0:    r[i] = 1'b0;
          2'd1:    r[i] = 1'b1;
          2'd2:    r[i] = ~d[i];
          default: r[i] = d[i] & d[(i + 1) % 32];
        endcase
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // present one access, sample the registered result after the capturing edge
  task automatic access(input logic v, input logic [1:0] k, input logic [15:0] a,
                        input logic [31:0] d);
    @(negedge clk);
    acc_valid = v; acc_kind = k; acc_addr = a; acc_data = d;
    @(posedge clk);
    #1;
    @(negedge clk);
    acc_valid = 1'b0; acc_kind = 2'd0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; trig_addr = 16'h1000; kind_en = 3'b000; time_en = 1'b0;
    time_thresh = '0; fault_mask = '0; fault_op = 2'd0; repeat_mode = 1'b1;
    rearm = 1'b0; acc_valid = 1'b0; acc_kind = 2'd0; acc_addr = '0; acc_data = '0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 valid in reset", 32'(out_valid), 32'd0);
    check("R1 pulse in reset", 32'(inj_pulse), 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 valid after reset", 32'(out_valid), 32'd0);
    check("R1 pulse after reset", 32'(inj_pulse), 32'd0);

    // table walk, repeat mode on (R2 R3 R5 R6 R7 R9 R10)
    for (int n = 0; n < NV; n++) begin
      @(negedge clk);
      kind_en = VECS[n].ken; fault_op = VECS[n].op; fault_mask = VECS[n].mask;
      acc_valid = VECS[n].valid; acc_kind = VECS[n].kind;
      acc_addr = VECS[n].addr; acc_data = VECS[n].data;
      @(posedge clk);
      #1;
      check($sformatf("R2 vec %0d valid", n), 32'(out_valid), 32'(VECS[n].exp_valid));
      check($sformatf("R10 vec %0d pulse", n), 32'(inj_pulse), 32'(VECS[n].exp_pulse));
      if (VECS[n].exp_valid)
        check($sformatf("R7 vec %0d data", n), out_data,
              VECS[n].exp_pulse ? model(VECS[n].op, VECS[n].mask, VECS[n].data)
                                : VECS[n].data);
    end
    @(negedge clk);
    acc_valid = 1'b0;

    // R9: two back-to-back matches both injected in repeat mode
    kind_en = 3'b001; fault_op = 2'd2; fault_mask = 32'h0000000F;
    access(1'b1, 2'd1, 16'h1000, 32'h00000000);
    check("R9 first repeat hit", out_data, 32'h0000000F);
    access(1'b1, 2'd1, 16'h1000, 32'h00000000);
    check("R9 second repeat hit", out_data, 32'h0000000F);

    // R8: one-shot, then rearm
    repeat_mode = 1'b0;
    access(1'b1, 2'd1, 16'h1000, 32'h00000000);
    check("R8 one-shot fires", 32'(inj_pulse), 32'd1);
    access(1'b1, 2'd1, 16'h1000, 32'h00000000);
    check("R8 disarmed pulse", 32'(inj_pulse), 32'd0);
    check("R8 disarmed data", out_data, 32'h00000000);
    @(negedge clk); rearm = 1'b1;
    @(negedge clk); rearm = 1'b0;
    access(1'b1, 2'd1, 16'h1000, 32'h00000000);
    check("R8 rearmed fires", 32'(inj_pulse), 32'd1);
    check("R8 rearmed data", out_data, 32'h0000000F);

    // R4/R5: time condition after a fresh reset
    repeat_mode = 1'b1; time_en = 1'b1; time_thresh = 16'd3000;
    kind_en = 3'b001; fault_op = 2'd1; fault_mask = 32'h00000100;
    do_reset();
    access(1'b1, 2'd1, 16'h1000, 32'h00000000);
    check("R4 before threshold", 32'(inj_pulse), 32'd0);
    check("R4 before threshold data", out_data, 32'h00000000);
    repeat (3100) @(posedge clk);
    access(1'b1, 2'd1, 16'h1000, 32'h00000000);
    check("R4 after threshold", 32'(inj_pulse), 32'd1);
    check("R4 after threshold data", out_data, 32'h00000100);
    access(1'b1, 2'd1, 16'h1200, 32'h00000000);
    check("R5 time ok but address wrong", 32'(inj_pulse), 32'd0);
    kind_en = 3'b000;
    access(1'b1, 2'd3, 16'h7777, 32'h00000000);
    check("R5 time only, any address", 32'(inj_pulse), 32'd1);
    repeat (50) @(posedge clk);
    access(1'b1, 2'd2, 16'h0001, 32'h00000000);
    check("R4 condition stays true", 32'(inj_pulse), 32'd1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule